// File: doc/BRIEF.md
# Operand Address Resolver for an 8-bit Processor Core

This unit works out where an instruction's operand lives, or what its immediate value is. It serves an 8-bit processor with a 16-bit address space. The caller presents an addressing-mode code, the program counter and the X, Y and A register values, then pulses `start`. The unit reads the operand bytes that follow the opcode through a byte-wide read port that has one cycle of latency. Where a mode needs it, the unit also reads a two-byte pointer from page zero. It returns the effective address, an operand byte, a zero-page address, the program counter advanced past the operand bytes, and a page-crossing flag. A one-cycle `done` pulse marks the end. Everything that follows, such as executing the instruction or writing results back, stays with the caller.

The unit applies the classic wrap rules. Zero-page indexing and pointer fetches never leave page zero. Full 16-bit sums wrap modulo 65536. Absolute indexed modes flag a page crossing. The caller ANDs that flag with its own per-instruction qualifier to get an extra-cycle request.

The controller is a state machine with these states:
- `ST_IDLE` waits for `start`.
- `ST_OPND_RD` issues the read of the first operand byte.
- `ST_OPND_LO` takes the first byte, may issue the read of the second byte, and finishes the one-byte modes.
- `ST_OPND_HI` takes the second byte and finishes the two-byte modes.
- `ST_PTR_LO` issues the read of the pointer's low byte.
- `ST_PTR_HI` takes the low byte and issues the read of the high byte.
- `ST_PTR_END` takes the high byte and forms the address.
- `ST_DONE` raises `done`.

The transitions are:
- IDLE→DONE for modes that read nothing, and IDLE→OPND_RD for every other mode.
- OPND_RD→OPND_LO.
- OPND_LO→OPND_HI for two-byte modes, OPND_LO→PTR_LO for pointer modes, and OPND_LO→DONE otherwise.
- OPND_HI→DONE.
- PTR_LO→PTR_HI→PTR_END→DONE.
- DONE→IDLE.

Top module: `opaddr_resolver`

## Requirements
- R1: Mode codes 0 (implied), 1 (accumulator), 14 and 15 return the A value on `operand`. They perform no reads, return `pc_out` equal to the PC and `ea` of 0, and raise `done` one cycle after `start`.
- R2: Mode 2 (immediate) returns the byte at PC on `operand`, sets `pc_out` to PC+1 and sets `ea` to 0.
- R3: Mode 3 (zero page) returns the byte at PC as the address. Modes 4 (zero page + X) and 5 (zero page + Y) add the index modulo 256. In all three modes the address's upper byte is 0 and `pc_out` is PC+1.
- R4: Mode 6 (relative) reads the offset at PC as a signed byte and adds it to PC+1 modulo 65536. The result goes on `ea`, and `pc_out` is PC+1.
- R5: Mode 7 (absolute) reads the byte at PC as the low half and the byte at PC+1 as the high half of `ea`. `pc_out` is PC+2.
- R6: Modes 8 (absolute + X) and 9 (absolute + Y) add the index to the absolute address modulo 65536. `page_cross` is 1 exactly when the result's high byte differs from the fetched high byte.
- R7: Mode 10 (indexed indirect) reads the pointer low byte at (b+X) mod 256 and the high byte at (b+X+1) mod 256, where b is the byte at PC. The pointer is `ea`, and `pc_out` is PC+1.
- R8: Mode 11 (indirect indexed) reads the pointer at b and (b+1) mod 256, then adds Y modulo 65536. `pc_out` is PC+1.
- R9: Mode 12 (zero-page indirect) reads the pointer at b and (b+1) mod 256 and applies no index. `pc_out` is PC+1.
- R10: Mode 13 (zero page + relative) returns the byte at PC on `zp_addr`. It returns PC+2 plus the signed byte at PC+1, modulo 65536, on `ea`, and sets `pc_out` to PC+2.
- R11: `page_cross` is 0 after every mode other than 8 and 9. `extra_cycle` equals `page_cross` AND `qual_in`.
- R12: The mode, PC and register inputs are sampled only on a `start` seen in idle, and a `start` seen while busy is ignored. `busy` is high while reads are in progress. `done` lasts exactly one cycle with `busy` low. The latency from `start` to `done` is 1, 3, 4 or 6 cycles, and the number of reads is 0, 1, 2 or 3, for modes with no operand byte, one operand byte, two operand bytes or a pointer respectively. The results hold until the next `start`.
- R13: While reset is held, `busy`, `done`, `rd_en`, `ea`, `operand`, `pc_out` and `page_cross` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving one instruction (accepted only while idle) |
| mode | input | 4 | Addressing-mode code, 0 to 15 |
| pc_in | input | AW | Address of the first operand byte |
| x_in | input | DW | X index value |
| y_in | input | DW | Y index value |
| a_in | input | DW | Accumulator value |
| qual_in | input | 1 | Instruction's extra-cycle qualifier |
| rd_en | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_data | input | DW | Read data, valid one cycle after the request |
| busy | output | 1 | Reads in progress |
| done | output | 1 | One-cycle completion pulse |
| ea | output | AW | Effective address or branch target |
| operand | output | DW | Immediate or accumulator operand |
| zp_addr | output | DW | Zero-page address for mode 13 |
| pc_out | output | AW | PC advanced past the operand bytes |
| page_cross | output | 1 | Indexed absolute address crossed a page |
| extra_cycle | output | 1 | page_cross AND qual_in |

## Verification
The bench builds the unit with its default DW of 8, which gives a 16-bit address. At that size random PC, index and operand values hit both kinds of wrap often: the 8-bit zero-page wrap and the 65536 wrap of absolute sums and branch targets. Directed cases plant memory bytes to force the exact edges:
- a pointer at 0xFF whose high byte comes from 0x00;
- an offset of 0x80;
- an index sum that carries into the next page.

A deliberate `start` in mid-fetch confirms that a running resolution is not disturbed.

// File: rtl/oa_pkg.sv
`timescale 1ns/1ps
package oa_pkg;

    typedef enum logic [3:0] {
        AM_IMP  = 4'd0,
        AM_ACC  = 4'd1,
        AM_IMM  = 4'd2,
        AM_ZP   = 4'd3,
        AM_ZPX  = 4'd4,
        AM_ZPY  = 4'd5,
        AM_REL  = 4'd6,
        AM_ABS  = 4'd7,
        AM_ABSX = 4'd8,
        AM_ABSY = 4'd9,
        AM_IZX  = 4'd10,
        AM_IZY  = 4'd11,
        AM_IZP  = 4'd12,
        AM_ZPR  = 4'd13
    } am_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPND_RD,
        ST_OPND_LO,
        ST_OPND_HI,
        ST_PTR_LO,
        ST_PTR_HI,
        ST_PTR_END,
        ST_DONE
    } st_t;

    // Codes above the last defined mode behave as implied.
    function automatic am_t norm_mode(input logic [3:0] code);
        if (code > 4'd13) return AM_IMP;
        return am_t'(code);
    endfunction

    function automatic logic two_byte(input am_t m);
        return (m == AM_ABS) || (m == AM_ABSX) || (m == AM_ABSY) || (m == AM_ZPR);
    endfunction

    function automatic logic ptr_mode(input am_t m);
        return (m == AM_IZX) || (m == AM_IZY) || (m == AM_IZP);
    endfunction

    function automatic logic no_fetch(input am_t m);
        return (m == AM_IMP) || (m == AM_ACC);
    endfunction

endpackage

// File: rtl/oa_index_add.sv
`timescale 1ns/1ps
// Adds an unsigned index to a double-width base, wrapping at the full width,
// and reports whether the upper half changed.
module oa_index_add #(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] idx,
    output logic [AW-1:0] sum,
    output logic          crossed
);
    always_comb begin
        sum     = base + {{DW{1'b0}}, idx};
        crossed = (sum[AW-1:DW] != base[AW-1:DW]);
    end
endmodule

// File: rtl/oa_rel_target.sv
`timescale 1ns/1ps
// Branch target: next PC plus a sign-extended byte offset, modulo 2**AW.
module oa_rel_target #(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic [AW-1:0] pc_next,
    input  logic [DW-1:0] offset,
    output logic [AW-1:0] target
);
    always_comb begin
        target = pc_next + {{DW{offset[DW-1]}}, offset};
    end
endmodule

// File: rtl/opaddr_resolver.sv
`timescale 1ns/1ps
module opaddr_resolver
    import oa_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] a_in,
    input  logic          qual_in,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic [DW-1:0] operand,
    output logic [DW-1:0] zp_addr,
    output logic [AW-1:0] pc_out,
    output logic          page_cross,
    output logic          extra_cycle
);
    localparam logic [AW-1:0] PC_ONE = AW'(1);
    localparam logic [AW-1:0] PC_TWO = AW'(2);
    localparam logic [DW-1:0] B_ONE  = DW'(1);

    st_t           st_q, st_d;
    am_t           mode_q;
    am_t           mode_new;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] x_q, y_q, a_q;
    logic [DW-1:0] b1_q, lo_q, ptr_q;
    logic [AW-1:0] ea_q, pcout_q;
    logic [DW-1:0] opnd_q, zp_q;
    logic          pcross_q;

    logic [DW-1:0] idx_sel, zp_idx, zp_sum, ptr_nx, ptr_base;
    logic [AW-1:0] add_base, add_sum, rel_pc, rel_tgt;
    logic          add_cross;

    assign mode_new = norm_mode(mode);

    // ---------------- shared arithmetic ----------------
    always_comb begin
        case (mode_q)
            AM_ABSX:         idx_sel = x_q;
            AM_ABSY, AM_IZY: idx_sel = y_q;
            default:         idx_sel = '0;
        endcase
        case (mode_q)
            AM_ZPX:  zp_idx = x_q;
            AM_ZPY:  zp_idx = y_q;
            default: zp_idx = '0;
        endcase
        zp_sum   = rd_data + zp_idx;
        ptr_base = rd_data + ((mode_q == AM_IZX) ? x_q : '0);
        ptr_nx   = ptr_q + B_ONE;
        add_base = (st_q == ST_PTR_END) ? {rd_data, lo_q} : {rd_data, b1_q};
        rel_pc   = pc_q + ((st_q == ST_OPND_HI) ? PC_TWO : PC_ONE);
    end

    oa_index_add #(.DW(DW)) u_idx (
        .base    (add_base),
        .idx     (idx_sel),
        .sum     (add_sum),
        .crossed (add_cross)
    );

    oa_rel_target #(.DW(DW)) u_rel (
        .pc_next (rel_pc),
        .offset  (rd_data),
        .target  (rel_tgt)
    );

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start) st_d = no_fetch(mode_new) ? ST_DONE : ST_OPND_RD;
            ST_OPND_RD: st_d = ST_OPND_LO;
            ST_OPND_LO: begin
                if (two_byte(mode_q))      st_d = ST_OPND_HI;
                else if (ptr_mode(mode_q)) st_d = ST_PTR_LO;
                else                       st_d = ST_DONE;
            end
            ST_OPND_HI: st_d = ST_DONE;
            ST_PTR_LO:  st_d = ST_PTR_HI;
            ST_PTR_HI:  st_d = ST_PTR_END;
            ST_PTR_END: st_d = ST_DONE;
            ST_DONE:    st_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // ---------------- captured operands and results ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= AM_IMP;
            pc_q     <= '0;
            x_q      <= '0;
            y_q      <= '0;
            a_q      <= '0;
            b1_q     <= '0;
            lo_q     <= '0;
            ptr_q    <= '0;
            ea_q     <= '0;
            pcout_q  <= '0;
            opnd_q   <= '0;
            zp_q     <= '0;
            pcross_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q   <= mode_new;
                        pc_q     <= pc_in;
                        x_q      <= x_in;
                        y_q      <= y_in;
                        a_q      <= a_in;
                        ea_q     <= '0;
                        zp_q     <= '0;
                        pcross_q <= 1'b0;
                        pcout_q  <= pc_in;
                        opnd_q   <= no_fetch(mode_new) ? a_in : '0;
                    end
                end
                ST_OPND_LO: begin
                    b1_q  <= rd_data;
                    ptr_q <= ptr_base;
                    if (!two_byte(mode_q)) pcout_q <= pc_q + PC_ONE;
                    case (mode_q)
                        AM_IMM:                opnd_q <= rd_data;
                        AM_ZP, AM_ZPX, AM_ZPY: ea_q   <= {{DW{1'b0}}, zp_sum};
                        AM_REL:                ea_q   <= rel_tgt;
                        default: ;
                    endcase
                end
                ST_OPND_HI: begin
                    pcout_q <= pc_q + PC_TWO;
                    if (mode_q == AM_ZPR) begin
                        zp_q <= b1_q;
                        ea_q <= rel_tgt;
                    end else begin
                        ea_q     <= add_sum;
                        pcross_q <= add_cross && ((mode_q == AM_ABSX) || (mode_q == AM_ABSY));
                    end
                end
                ST_PTR_HI:  lo_q <= rd_data;
                ST_PTR_END: ea_q <= add_sum;
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        rd_en   = 1'b0;
        rd_addr = '0;
        unique case (st_q)
            ST_IDLE: ;
            ST_OPND_RD: begin
                busy    = 1'b1;
                rd_en   = 1'b1;
                rd_addr = pc_q;
            end
            ST_OPND_LO: begin
                busy = 1'b1;
                if (two_byte(mode_q)) begin
                    rd_en   = 1'b1;
                    rd_addr = pc_q + PC_ONE;
                end
            end
            ST_OPND_HI: busy = 1'b1;
            ST_PTR_LO: begin
                busy    = 1'b1;
                rd_en   = 1'b1;
                rd_addr = {{DW{1'b0}}, ptr_q};
            end
            ST_PTR_HI: begin
                busy    = 1'b1;
                rd_en   = 1'b1;
                rd_addr = {{DW{1'b0}}, ptr_nx};
            end
            ST_PTR_END: busy = 1'b1;
            ST_DONE:    done = 1'b1;
        endcase
        ea          = ea_q;
        operand     = opnd_q;
        zp_addr     = zp_q;
        pc_out      = pcout_q;
        page_cross  = pcross_q;
        extra_cycle = pcross_q & qual_in;
    end

endmodule

// File: rtl/oa_checker.sv
`timescale 1ns/1ps
module oa_checker
    import oa_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          rd_en,
    input logic [AW-1:0] ea,
    input logic          page_cross,
    input logic          extra_cycle,
    input am_t           mode_q
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R12
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R12
    AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> busy); // R12
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !done && !start) |=> $stable(ea)); // R12
    AST_EXTRA_NEEDS_CROSS: assert property (@(posedge clk) disable iff (!rst_n) extra_cycle |-> page_cross); // R11
    AST_CROSS_ONLY_ABS_IDX: assert property (@(posedge clk) disable iff (!rst_n) page_cross |-> (mode_q == AM_ABSX || mode_q == AM_ABSY)); // R6
    AST_ZP_STAYS_PAGE0: assert property (@(posedge clk) disable iff (!rst_n) (done && (mode_q == AM_ZP || mode_q == AM_ZPX || mode_q == AM_ZPY)) |-> (ea[AW-1:DW] == '0)); // R3
endmodule

bind opaddr_resolver oa_checker #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .rd_en       (rd_en),
    .ea          (ea),
    .page_cross  (page_cross),
    .extra_cycle (extra_cycle),
    .mode_q      (mode_q)
);

// File: tb/opaddr_resolver_test.sv
`timescale 1ns/1ps
module opaddr_resolver_test;
    localparam int DW = 8;
    localparam int AW = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n, start, qual_in, rd_en, busy, done, page_cross, extra_cycle;
    logic [3:0]    mode;
    logic [AW-1:0] pc_in, rd_addr, ea, pc_out;
    logic [DW-1:0] x_in, y_in, a_in, rd_data, operand, zp_addr;

    opaddr_resolver #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc_in(pc_in),
        .x_in(x_in), .y_in(y_in), .a_in(a_in), .qual_in(qual_in),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .ea(ea), .operand(operand), .zp_addr(zp_addr),
        .pc_out(pc_out), .page_cross(page_cross), .extra_cycle(extra_cycle)
    );

    int n_chk = 0;
    int n_bad = 0;

    // memory model: computed content plus a few planted bytes
    logic [15:0] pk_a [4];
    logic [7:0]  pk_d [4];
    logic        pk_v [4];

    function automatic logic [7:0] memf(input logic [15:0] a);
        logic [7:0] v;
        for (int i = 0; i < 4; i++) if (pk_v[i] && pk_a[i] == a) return pk_d[i];
        v = (a[7:0] * 8'd37) ^ (a[15:8] * 8'd11) ^ 8'h5A;
        return v;
    endfunction

    always @(posedge clk) rd_data <= rd_en ? memf(rd_addr) : 8'h00;

    task automatic clear_pk();
        for (int i = 0; i < 4; i++) begin pk_v[i] = 1'b0; pk_a[i] = '0; pk_d[i] = '0; end
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'd2:             return "R2";
            4'd3, 4'd4, 4'd5: return "R3";
            4'd6:             return "R4";
            4'd7:             return "R5";
            4'd8, 4'd9:       return "R6";
            4'd10:            return "R7";
            4'd11:            return "R8";
            4'd12:            return "R9";
            4'd13:            return "R10";
            default:          return "R1";
        endcase
    endfunction

    function automatic logic [15:0] sx(input logic [7:0] b);
        return {{8{b[7]}}, b};
    endfunction

    task automatic run_op(input logic [3:0] md, input logic [15:0] p, input logic [7:0] xx,
                          input logic [7:0] yy, input logic [7:0] aa, input logic q, input logic disturb);
        logic [15:0] e_ea, e_pc, base;
        logic [7:0]  e_op, e_zp, b1, b2, pt, lo, hi;
        logic        e_x;
        int          e_lat, e_rd, lat, reads;
        string       rq;
        b1 = memf(p); b2 = memf(p + 16'd1);
        e_ea = 16'h0; e_op = 8'h0; e_zp = 8'h0; e_x = 1'b0; e_pc = p + 16'd1;
        e_lat = 3; e_rd = 1;
        case (md)
            4'd2: e_op = b1;
            4'd3: e_ea = {8'h00, b1};
            4'd4: e_ea = {8'h00, 8'(b1 + xx)};
            4'd5: e_ea = {8'h00, 8'(b1 + yy)};
            4'd6: e_ea = p + 16'd1 + sx(b1);
            4'd7, 4'd8, 4'd9: begin
                base = {b2, b1};
                e_ea = base + ((md == 4'd8) ? {8'h0, xx} : (md == 4'd9) ? {8'h0, yy} : 16'h0);
                e_x = (e_ea[15:8] != b2);
                e_pc = p + 16'd2; e_lat = 4; e_rd = 2;
            end
            4'd10, 4'd11, 4'd12: begin
                pt = (md == 4'd10) ? 8'(b1 + xx) : b1;
                lo = memf({8'h00, pt});
                hi = memf({8'h00, 8'(pt + 8'd1)});
                e_ea = {hi, lo} + ((md == 4'd11) ? {8'h0, yy} : 16'h0);
                e_lat = 6; e_rd = 3;
            end
            4'd13: begin
                e_zp = b1; e_ea = p + 16'd2 + sx(b2);
                e_pc = p + 16'd2; e_lat = 4; e_rd = 2;
            end
            default: begin e_op = aa; e_pc = p; e_lat = 1; e_rd = 0; end
        endcase
        rq = req_of(md);

        @(negedge clk);
        mode = md; pc_in = p; x_in = xx; y_in = yy; a_in = aa; qual_in = q; start = 1'b1;
        @(negedge clk);
        start = 1'b0; mode = ~md; pc_in = ~p; x_in = ~xx; y_in = ~yy; a_in = ~aa;
        lat = 1; reads = 0;
        while (!done && lat < 20) begin
            if (rd_en) reads++;
            start = (disturb && lat == 2) ? 1'b1 : 1'b0;
            if (start) mode = 4'd0;
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check("R12", "latency", lat, e_lat);
        check("R12", "read count", reads, e_rd);
        check(rq, "ea", ea, e_ea);
        check(rq, "operand", operand, e_op);
        check(rq, "zp_addr", zp_addr, e_zp);
        check(rq, "pc_out", pc_out, e_pc);
        check((md == 4'd8 || md == 4'd9) ? "R6" : "R11", "page_cross", page_cross, e_x);
        check("R11", "extra_cycle", extra_cycle, e_x & q);
        @(negedge clk);
        check("R12", "done single pulse", done, 1'b0);
        check("R12", "result held", ea, e_ea);
    endtask

    initial begin
        #750000;
        n_bad++;
        $display("FAIL R12 watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        clear_pk();
        rst_n = 1'b0; start = 1'b0; mode = '0; pc_in = '0; x_in = '0; y_in = '0; a_in = '0; qual_in = 1'b0;
        repeat (4) @(negedge clk);
        // R13 reset state
        check("R13", "busy", busy, 1'b0);
        check("R13", "done", done, 1'b0);
        check("R13", "rd_en", rd_en, 1'b0);
        check("R13", "ea", ea, 16'h0);
        check("R13", "operand", operand, 8'h0);
        check("R13", "pc_out", pc_out, 16'h0);
        check("R13", "page_cross", page_cross, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 implied, accumulator and unused codes
        run_op(4'd0, 16'h1234, 8'h11, 8'h22, 8'hA5, 1'b0, 1'b0);
        run_op(4'd1, 16'hFFFF, 8'h11, 8'h22, 8'h3C, 1'b1, 1'b0);
        run_op(4'd15, 16'h0200, 8'h00, 8'h00, 8'h77, 1'b0, 1'b0);

        // R3 zero page + X wraps in page zero
        pk_v[0] = 1; pk_a[0] = 16'h0300; pk_d[0] = 8'hF0;
        run_op(4'd4, 16'h0300, 8'h20, 8'h00, 8'h00, 1'b0, 1'b0);
        clear_pk();

        // R4 relative with offset 0x80 wrapping below zero
        pk_v[0] = 1; pk_a[0] = 16'h0000; pk_d[0] = 8'h80;
        run_op(4'd6, 16'h0000, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
        clear_pk();

        // R6 absolute + X crossing a page, qualifier set
        pk_v[0] = 1; pk_a[0] = 16'h1000; pk_d[0] = 8'hF0;
        pk_v[1] = 1; pk_a[1] = 16'h1001; pk_d[1] = 8'h12;
        run_op(4'd8, 16'h1000, 8'h20, 8'h00, 8'h00, 1'b1, 1'b0);
        // R6 absolute + Y crossing, qualifier clear
        run_op(4'd9, 16'h1000, 8'h00, 8'h20, 8'h00, 1'b0, 1'b0);
        // R6 absolute + Y wrapping at 65536
        pk_d[1] = 8'hFF;
        run_op(4'd9, 16'h1000, 8'h00, 8'h20, 8'h00, 1'b1, 1'b0);
        clear_pk();

        // R8 pointer at 0xFF takes its high byte from 0x00
        pk_v[0] = 1; pk_a[0] = 16'h2000; pk_d[0] = 8'hFF;
        pk_v[1] = 1; pk_a[1] = 16'h00FF; pk_d[1] = 8'hF0;
        pk_v[2] = 1; pk_a[2] = 16'h0000; pk_d[2] = 8'h12;
        run_op(4'd11, 16'h2000, 8'h00, 8'h20, 8'h00, 1'b1, 1'b0);
        // R9 same pointer, no index
        run_op(4'd12, 16'h2000, 8'h00, 8'h20, 8'h00, 1'b0, 1'b0);
        // R7 (b + X) wraps to 0xFF
        pk_d[0] = 8'hF0;
        run_op(4'd10, 16'h2000, 8'h0F, 8'h00, 8'h00, 1'b0, 1'b0);
        // R12 start during fetch is ignored
        run_op(4'd10, 16'h2000, 8'h0F, 8'h00, 8'h00, 1'b0, 1'b1);
        clear_pk();

        // R10 zero page + relative, negative offset
        pk_v[0] = 1; pk_a[0] = 16'h4000; pk_d[0] = 8'h42;
        pk_v[1] = 1; pk_a[1] = 16'h4001; pk_d[1] = 8'hFE;
        run_op(4'd13, 16'h4000, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
        clear_pk();

        // R2 immediate at the top of memory
        run_op(4'd2, 16'hFFFF, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);

        // random mix over every mode code
        for (int i = 0; i < 400; i++) begin
            run_op(4'($urandom % 16), 16'($urandom), 8'($urandom), 8'($urandom),
                   8'($urandom), 1'($urandom), 1'(($urandom % 8) == 0));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule